// File: doc/BRIEF.md
# Thread-Sharing Table and Instruction Splitter

This block sits between decode and rename in a four-thread core that fetches an instruction once for every thread whose program counter matches. Each fetched instruction carries a thread mask. The block decides whether that instruction can execute once for all threads in the mask, or whether it has to become several copies. It makes the decision from a table that holds one entry per architected register. Each entry records, for every pair of threads, whether the two threads are known to hold the same value in that register.

For each incoming instruction the block reads the entries of its enabled source registers and ANDs them together. From the result it derives which groups of threads may share one execution. It then splits the mask greedily into the fewest groups it can, largest group first, and returns up to four output masks in a single cycle.

On the clock edge that ends the cycle, the entry of the destination register is rewritten so that it reflects the split just made. The start state of the table depends on the workload type, which is sampled during reset.

Top module: `share_splitter`

## Requirements
- R1: After a reset with `mt_mode` low, every pair bit of every entry is 1. A mask-1111 instruction that reads any register then yields the single output 1111.
- R2: After a reset with `mt_mode` high, the entry of register `SP_REG` is all 0 and every other entry is all 1.
- R3: Mask bit t stands for thread t. The pair-bit positions are fixed: bit 0 = threads (0,1), bit 1 = (0,2), bit 2 = (0,3), bit 3 = (1,2), bit 4 = (1,3), bit 5 = (2,3). A group of threads may execute once only if every pair inside the group has its bit set in the entry of every enabled source. With no enabled source, all groups are shareable.
- R4: Every output group is a subset of the incoming mask. The valid output masks are pairwise disjoint, and together they cover the incoming mask exactly.
- R5: Each slot takes the shareable group with the most threads among the threads not yet covered. When two candidate groups are the same size, the one with the lower numeric mask value wins.
- R6: Outputs are packed from slot 0 upward. `out_valid` is contiguous from bit 0, and `out_count` equals the number of valid slots. Unused slots read 0000. When `in_valid` is low, no slot is valid.
- R7: A mask of 1111 whose inputs differ between every thread pair yields four slots, in this order: 0001, 0010, 0100, 1000.
- R8: When a valid instruction has `dst_en` high, each pair bit of the destination entry with at least one of its threads in the mask becomes 1 if some output mask holds both threads, and 0 otherwise. Every other bit of that entry keeps its value.
- R9: A valid single-thread instruction with a destination clears every pair bit of that destination entry that involves its thread.
- R10: When `in_valid` is low or `dst_en` is low, the table does not change.
- R11: Sources are read from the table as it stood before the current instruction. An update becomes visible to the instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_mode | input | 1 | Workload type sampled during reset: 1 = shared-memory threads, 0 = independent instances |
| in_valid | input | 1 | Instruction present this cycle |
| in_mask | input | 4 | Threads the instruction was fetched for |
| src0_en | input | 1 | First source register used |
| src0_idx | input | IW | First source register index |
| src1_en | input | 1 | Second source register used |
| src1_idx | input | IW | Second source register index |
| dst_en | input | 1 | Instruction writes a destination register |
| dst_idx | input | IW | Destination register index |
| out_valid | output | 4 | Valid bit of each output slot |
| out_mask | output | 16 | Output thread masks; slot k occupies bits 4k+3..4k |
| out_count | output | 3 | Number of valid output slots |

## Verification
The assertions assume that every register index is below `NUM_REGS` and that inputs are stable for the whole cycle in which they are sampled. The split outputs are combinational, so the checks on cover, disjointness and packing read them at the clock edge of the same cycle. The stimulus draws indices only from a small range inside the table, so that entries are reused often, and it drives all inputs on the falling edge. The stimulus includes mask 0000 and invalid cycles, so the assertions also see cycles that must produce no output and leave the table unchanged.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

    localparam int NTHR  = 4;
    localparam int NPAIR = NTHR * (NTHR - 1) / 2;
    localparam int NGRP  = 1 << NTHR;

    typedef logic [NTHR-1:0]  tmask_t;
    typedef logic [NPAIR-1:0] pairv_t;

    typedef struct packed {
        logic [NTHR-1:0]   vld;
        tmask_t [NTHR-1:0] m;
    } split_t;

    // lower-numbered thread of pair p
    function automatic int unsigned lo_thr(int unsigned p);
        case (p)
            0, 1, 2: return 0;
            3, 4:    return 1;
            default: return 2;
        endcase
    endfunction

    // higher-numbered thread of pair p
    function automatic int unsigned hi_thr(int unsigned p);
        case (p)
            0:       return 1;
            1, 3:    return 2;
            default: return 3;
        endcase
    endfunction

    // pairs whose two threads are both inside m
    function automatic pairv_t pairs_within(tmask_t m);
        pairv_t r;
        for (int p = 0; p < NPAIR; p++)
            r[p] = m[lo_thr(p)] & m[hi_thr(p)];
        return r;
    endfunction

    // pairs with at least one thread inside m
    function automatic pairv_t pairs_touching(tmask_t m);
        pairv_t r;
        for (int p = 0; p < NPAIR; p++)
            r[p] = m[lo_thr(p)] | m[hi_thr(p)];
        return r;
    endfunction

    function automatic int unsigned size_of(tmask_t m);
        int unsigned n = 0;
        for (int t = 0; t < NTHR; t++)
            n += int'(m[t]);
        return n;
    endfunction

endpackage

// File: rtl/share_table.sv
module share_table
    import rsplit_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int SP_REG   = 29,
    localparam int IW      = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mt_mode,
    input  logic                          wr_en,
    input  logic [IW-1:0]                 wr_idx,
    input  pairv_t                        wr_touch,
    input  pairv_t                        wr_val,
    output pairv_t [NUM_REGS-1:0]         tbl_q
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
        localparam bit IS_SP = (r == SP_REG);
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[r] <= (mt_mode && IS_SP) ? '0 : '1;
            else if (wr_en && wr_idx == IW'(r))
                tbl_q[r] <= (tbl_q[r] & ~wr_touch) | (wr_val & wr_touch);
        end
    end

    // no write request leaves every entry as it was
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tbl_q));

endmodule

// File: rtl/group_eval.sv
module group_eval
    import rsplit_pkg::*;
(
    input  pairv_t            share,
    output logic [NGRP-1:0]   grp_ok
);

    // a group may run once when every pair inside it shares; singletons need no pair
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g == 0) begin : g_empty
            assign grp_ok[g] = 1'b0;
        end else begin : g_real
            localparam pairv_t NEED = pairs_within(tmask_t'(g));
            assign grp_ok[g] = ((NEED & ~share) == '0);
        end
    end

endmodule

// File: rtl/split_chooser.sv
module split_chooser
    import rsplit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tmask_t           mask,
    input  logic [NGRP-1:0]  grp_ok,
    output split_t           res
);

    function automatic tmask_t pick_largest(tmask_t rem, logic [NGRP-1:0] ok);
        tmask_t      best = '0;
        int unsigned bsz  = 0;
        for (int g = 1; g < NGRP; g++) begin
            tmask_t c = tmask_t'(g);
            if (((c & ~rem) == '0) && ok[g] && size_of(c) > bsz) begin
                best = c;
                bsz  = size_of(c);
            end
        end
        return best;
    endfunction

    tmask_t [NTHR:0] rem;
    assign rem[0] = mask;

    for (genvar k = 0; k < NTHR; k++) begin : g_stage
        tmask_t pick;
        assign pick       = pick_largest(rem[k], grp_ok);
        assign res.m[k]   = pick;
        assign res.vld[k] = (rem[k] != '0);
        assign rem[k+1]   = rem[k] & ~pick;

        // every issued group is one the sharing evaluation allowed
        assert_grp_allowed_R3: assert property (@(posedge clk) disable iff (rst)
            res.vld[k] |-> grp_ok[res.m[k]]);
        // issued group never reaches outside the incoming mask
        assert_subset_R4: assert property (@(posedge clk) disable iff (rst)
            (res.m[k] & ~mask) == '0);
    end

endmodule

// File: rtl/share_splitter.sv
module share_splitter
    import rsplit_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int SP_REG   = 29,
    localparam int IW      = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mt_mode,
    input  logic          in_valid,
    input  logic [3:0]    in_mask,
    input  logic          src0_en,
    input  logic [IW-1:0] src0_idx,
    input  logic          src1_en,
    input  logic [IW-1:0] src1_idx,
    input  logic          dst_en,
    input  logic [IW-1:0] dst_idx,
    output logic [3:0]    out_valid,
    output logic [15:0]   out_mask,
    output logic [2:0]    out_count
);

    pairv_t [NUM_REGS-1:0] tbl_q;
    pairv_t                share;
    logic [NGRP-1:0]       grp_ok;
    split_t                res;
    tmask_t                eff_mask;
    logic                  wr_en;
    pairv_t                wr_touch;
    pairv_t                wr_val;

    share_table #(.NUM_REGS(NUM_REGS), .SP_REG(SP_REG)) u_tbl (
        .clk(clk), .rst(rst), .mt_mode(mt_mode),
        .wr_en(wr_en), .wr_idx(dst_idx), .wr_touch(wr_touch), .wr_val(wr_val),
        .tbl_q(tbl_q)
    );

    // AND the source entries; an unused source constrains nothing
    always_comb begin
        share = '1;
        if (src0_en) share &= tbl_q[src0_idx];
        if (src1_en) share &= tbl_q[src1_idx];
    end

    group_eval u_eval (.share(share), .grp_ok(grp_ok));

    assign eff_mask = in_valid ? tmask_t'(in_mask) : '0;

    split_chooser u_choose (
        .clk(clk), .rst(rst), .mask(eff_mask), .grp_ok(grp_ok), .res(res)
    );

    // destination entry rewrite
    always_comb begin
        wr_en    = in_valid && dst_en;
        wr_touch = pairs_touching(eff_mask);
        wr_val   = '0;
        for (int k = 0; k < NTHR; k++)
            if (res.vld[k]) wr_val |= pairs_within(res.m[k]);
    end

    always_comb begin
        out_count = '0;
        for (int k = 0; k < NTHR; k++)
            out_count += 3'(res.vld[k]);
    end

    assign out_valid = res.vld;
    assign out_mask  = res.m;

    assert_cover_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (res.m[0] | res.m[1] | res.m[2] | res.m[3]) == in_mask);

    assert_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
        ((res.m[0] & res.m[1]) | (res.m[0] & res.m[2]) | (res.m[0] & res.m[3]) |
         (res.m[1] & res.m[2]) | (res.m[1] & res.m[3]) | (res.m[2] & res.m[3])) == '0);

    assert_packed_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid == 4'b0000 || out_valid == 4'b0001 ||
        out_valid == 4'b0011 || out_valid == 4'b0111 || out_valid == 4'b1111);

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> out_valid == 4'b0000);

    assert_single_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_en && $countones(in_mask) == 1) |=>
        (tbl_q[$past(dst_idx)] & pairs_touching($past(in_mask))) == '0);

    assert_untouched_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_en) |=>
        (tbl_q[$past(dst_idx)] & ~pairs_touching($past(in_mask))) ==
        ($past(tbl_q[dst_idx]) & ~pairs_touching($past(in_mask))));

endmodule

// File: tb/tb_share_splitter.sv
module tb_share_splitter;

    localparam int NR = 32;
    localparam int SP = 29;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mt_mode = 1'b1;
    logic          in_valid = 1'b0;
    logic [3:0]    in_mask = '0;
    logic          src0_en = 1'b0, src1_en = 1'b0, dst_en = 1'b0;
    logic [IW-1:0] src0_idx = '0, src1_idx = '0, dst_idx = '0;
    logic [3:0]    out_valid;
    logic [15:0]   out_mask;
    logic [2:0]    out_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [5:0] mdl [NR];

    always #2 clk = ~clk;

    share_splitter #(.NUM_REGS(NR), .SP_REG(SP)) dut (.*);

    // pair position as given in R3
    function automatic int pidx(int a, int b);
        if (a == 0) return b - 1;
        if (a == 1) return b + 1;
        return 5;
    endfunction

    function automatic bit may_share(logic [3:0] g, logic [5:0] sh);
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                if (g[a] && g[b] && !sh[pidx(a, b)]) return 0;
        return 1;
    endfunction

    function automatic int cnt(logic [3:0] g);
        return int'(g[0]) + int'(g[1]) + int'(g[2]) + int'(g[3]);
    endfunction

    // R5: per slot, try sizes from largest down, lowest value first
    function automatic logic [15:0] exp_split(logic [3:0] m, logic [5:0] sh);
        logic [15:0] r = '0;
        logic [3:0]  left = m;
        for (int s = 0; s < 4; s++) begin
            bit found = 0;
            for (int sz = 4; sz >= 1 && !found; sz--)
                for (int g = 1; g < 16 && !found; g++)
                    if (cnt(4'(g)) == sz && (4'(g) & ~left) == 0 && may_share(4'(g), sh)) begin
                        r[4*s +: 4] = 4'(g);
                        left &= ~4'(g);
                        found = 1;
                    end
        end
        return r;
    endfunction

    task automatic model_reset(bit mt);
        for (int r = 0; r < NR; r++) mdl[r] = (mt && r == SP) ? 6'h00 : 6'h3f;
    endtask

    task automatic do_reset(bit mt);
        @(negedge clk);
        rst = 1'b1; mt_mode = mt; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset(mt);
    endtask

    task automatic issue(input bit v, input logic [3:0] m,
                         input bit e0, input int i0, input bit e1, input int i1,
                         input bit ed, input int id, input string req);
        logic [5:0]  sh;
        logic [15:0] em;
        logic [3:0]  ev;
        int          ec;
        @(negedge clk);
        in_valid = v; in_mask = m;
        src0_en = e0; src0_idx = IW'(i0);
        src1_en = e1; src1_idx = IW'(i1);
        dst_en = ed; dst_idx = IW'(id);
        #1;
        sh = 6'h3f;
        if (e0) sh &= mdl[i0];
        if (e1) sh &= mdl[i1];
        em = v ? exp_split(m, sh) : 16'h0;
        ev = '0; ec = 0;
        for (int s = 0; s < 4; s++)
            if (em[4*s +: 4] != 0) begin ev[s] = 1'b1; ec++; end
        checks++;
        if (out_valid !== ev || out_mask !== em || out_count !== 3'(ec)) begin
            errors++;
            $display("FAIL %s: valid=%b mask=%h count=%0d expected valid=%b mask=%h count=%0d",
                     req, out_valid, out_mask, out_count, ev, em, ec);
        end
        // R8: destination rewrite in the model
        if (v && ed)
            for (int a = 0; a < 4; a++)
                for (int b = a + 1; b < 4; b++)
                    if (m[a] || m[b]) begin
                        bit both = 0;
                        for (int s = 0; s < 4; s++)
                            if (em[4*s + a] && em[4*s + b]) both = 1;
                        mdl[id][pidx(a, b)] = both;
                    end
    endtask

    task automatic probe(int r, string req);
        issue(1, 4'b1111, 1, r, 0, 0, 0, 0, req);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1);
        probe(SP, "R2_R7 sp split four ways");
        probe(5, "R2 other register shared");
        issue(1, 4'b0110, 1, SP, 0, 0, 0, 0, "R4 filter 0110 on sp");
        issue(1, 4'b1011, 1, 3, 0, 0, 0, 0, "R4 shared partial mask");
        issue(1, 4'b0001, 0, 0, 0, 0, 1, 7, "R9 single thread write");
        probe(7, "R9_R5 thread0 split off");
        issue(1, 4'b1111, 1, SP, 0, 0, 1, 8, "R7 all differ to dst 8");
        issue(1, 4'b0011, 0, 0, 0, 0, 1, 8, "R8 pair 01 set");
        issue(1, 4'b1100, 0, 0, 0, 0, 1, 8, "R8 pair 23 set");
        probe(8, "R5 tie lowest value first");
        issue(0, 4'b0001, 1, 8, 0, 0, 1, 8, "R6 idle no output");
        probe(8, "R10 invalid left table");
        issue(1, 4'b0100, 1, 8, 0, 0, 0, 8, "R10 dst disabled");
        probe(8, "R10 disabled dst left table");
        issue(1, 4'b1111, 1, 7, 1, 8, 0, 0, "R3 two sources ANDed");
        issue(1, 4'b1111, 0, 0, 0, 0, 0, 0, "R3 no sources shared");
        issue(1, 4'b0000, 1, SP, 0, 0, 1, 9, "R6 empty mask");
        issue(1, 4'b0010, 1, 9, 0, 0, 1, 9, "R11 read before write");
        probe(9, "R11 update visible next");
        for (int n = 0; n < 400; n++) begin
            int r0 = int'($urandom_range(0, 5));
            int r1 = int'($urandom_range(0, 5));
            int rd = int'($urandom_range(0, 5));
            if (r0 == 5) r0 = SP;
            issue($urandom_range(0, 9) != 0, 4'($urandom_range(0, 15)),
                  $urandom_range(0, 3) != 0, r0, $urandom_range(0, 1) != 0, r1,
                  $urandom_range(0, 3) != 0, rd, "R4_R5_R8 random");
        end
        do_reset(0);
        probe(SP, "R1 sp shared after independent reset");
        issue(1, 4'b0101, 1, 1, 1, 2, 0, 0, "R1 partial mask shared");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule